// File: doc/BRIEF.md
# Event Timer Global Register Block

This block is the shared front end of a multi-channel event timer. It owns a 64-bit main counter that advances by one on every clock while the timer is enabled. It also holds the global configuration bits (run enable and legacy interrupt routing), a per-channel interrupt status register and a read-only capability word. It decodes a 1 KB register window that is reached through 32-bit word accesses. Byte and halfword accesses, misaligned words and unmapped offsets read as zero and change nothing.

The comparator channels sit outside this block. Each channel receives a one-hot select, the offset inside its 32-byte window and a write qualifier. It returns its read word on a packed bus. The block tells the channels when to start and stop. An enable rise sends a one-cycle arm strobe to every channel that does not report an all-ones comparator. An enable fall sends a one-cycle disarm strobe to all channels. The counter value and the enable and legacy flags are driven straight to the channels.

Top module: `evt_timer_regs`

## Requirements
- R1: While reset is asserted and after it is released, before any access, the counter, the configuration, the status, the arm and disarm strobes and the enable and legacy outputs are all zero.
- R2: A word read at offset 0x000 returns the capability word: bits [7:0] = 0x01, bits [12:8] = number of channels minus one, bit 13 = 1 (64-bit counter), bit 14 = 0, bit 15 = 1 (legacy routing), bits [31:16] = 0x8086. With three channels this is 0x8086A201. A word read at 0x004 returns the tick period in femtoseconds (default 10,000,000).
- R3: Only accesses with size code 2 (word; 0 = byte, 1 = halfword) and address bits [1:0] = 0 are honoured. Other reads return zero and other writes change no state.
- R4: A word write at 0x010 sets the enable from data bit 0 and legacy from bit 1. The other bits read back as zero. Writes at 0x014 are ignored and that offset reads zero.
- R5: The main counter increments by exactly one per clock while enabled and holds its value while disabled. It carries from the low word into the high word.
- R6: A word write at 0x0F0 replaces counter bits [31:0] and a write at 0x0F4 replaces bits [63:32]. The other half keeps its current value. The write takes effect even while enabled, and that cycle has no increment.
- R7: A configuration write that changes the enable from 0 to 1 pulses arm for exactly one cycle, in the cycle after the write. The pulse goes to each channel whose all-ones comparator flag is low.
- R8: A configuration write that changes the enable from 1 to 0 pulses disarm to every channel for exactly one cycle, in the cycle after the write.
- R9: Offsets 0x100 to 0x3FF form channel windows of 0x20 bytes each, with channel k at 0x100 + 0x20*k. A word access there asserts only that channel's select, presents the offset bits [4:0] and returns that channel's read word. A window index at or beyond the channel count selects nothing and reads zero.
- R10: A channel's fire input sets its status bit at offset 0x020. Writing a 1 to a bit clears it. A fire in the same cycle as the clear wins.
- R11: The legacy output follows configuration bit 1 from the cycle after the write.
- R12: Word reads of unmapped offsets below 0x100 (for example 0x030) return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Register access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word |
| acc_addr | input | 10 | Byte address in the window |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid in the access cycle |
| ch_sel | output | NCH | One-hot channel window select |
| ch_wr | output | 1 | Selected channel access is a write |
| ch_reg_off | output | 5 | Byte offset inside the channel window |
| ch_rdata | input | NCH*32 | Read words from the channels, channel 0 lowest |
| ch_fire | input | NCH | Channel fire events |
| ch_cmp_ones | input | NCH | Channel comparator is all ones |
| ch_arm | output | NCH | One-cycle arm strobes |
| ch_disarm | output | NCH | One-cycle disarm strobes |
| cnt_value | output | 64 | Main counter value |
| glb_enable | output | 1 | Global enable flag |
| glb_legacy | output | 1 | Legacy routing flag |

## Verification
Read data, channel select and offset are combinational, so they are due in the access cycle itself. The bench samples them one time unit after the falling edge on which it drives the access. Counter, configuration, status and strobes are registered and change at the rising edge that ends a write cycle. A behavioural reference model steps on that same rising edge, and its state is compared with the outputs at every following falling edge. The arm and disarm pulses are also checked directly on the falling edge right after the write, and found cleared one cycle later.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [3:0] {
    RS_NONE,
    RS_CAP_LO,
    RS_CAP_HI,
    RS_CFG_LO,
    RS_CFG_HI,
    RS_STS,
    RS_CNT_LO,
    RS_CNT_HI,
    RS_CHAN
  } rsel_e;
endpackage

// File: rtl/evt_addr_decode.sv
module evt_addr_decode
  import evt_timer_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en_i,
  input  logic [1:0]        acc_size_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  output rsel_e             sel_o,
  output logic [NCH-1:0]    ch_sel_o,
  output logic [4:0]        ch_off_o
);
  localparam logic [5:0] NCH6 = 6'(NCH);

  logic              word_ok;
  logic              in_chan;
  logic [ADDR_W-1:0] rel;
  logic [4:0]        idx;

  assign word_ok  = acc_en_i && (acc_size_i == SZ_WORD) && (acc_addr_i[1:0] == 2'b00);
  assign in_chan  = (acc_addr_i[9:8] != 2'b00);
  assign rel      = acc_addr_i - 10'h100;
  assign idx      = rel[9:5];
  assign ch_off_o = rel[4:0];

  always_comb begin
    sel_o = RS_NONE;
    if (word_ok) begin
      if (in_chan) begin
        sel_o = ({1'b0, idx} < NCH6) ? RS_CHAN : RS_NONE;
      end else begin
        case (acc_addr_i[7:0])
          8'h00:   sel_o = RS_CAP_LO;
          8'h04:   sel_o = RS_CAP_HI;
          8'h10:   sel_o = RS_CFG_LO;
          8'h14:   sel_o = RS_CFG_HI;
          8'h20:   sel_o = RS_STS;
          8'hF0:   sel_o = RS_CNT_LO;
          8'hF4:   sel_o = RS_CNT_HI;
          default: sel_o = RS_NONE;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_sel
    assign ch_sel_o[g] = (sel_o == RS_CHAN) && (idx == 5'(g));
  end

  // R3 / R9: a channel is only ever selected by a valid word access
  a_r3_chan_word_only: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_sel_o) |-> (acc_en_i && acc_size_i == SZ_WORD && acc_addr_i[9:8] != 2'b00));
endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [31:0]      wdata_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_ce = 1'b0;
    if (wr_lo_i) begin
      cnt_d[31:0] = wdata_i;
      cnt_ce      = 1'b1;
    end else if (wr_hi_i) begin
      cnt_d[CNT_W-1:32] = wdata_i[CNT_W-33:0];
      cnt_ce            = 1'b1;
    end else if (run_i) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  a_r5_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_q));
  a_r5_step_when_on: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !wr_lo_i && !wr_hi_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r6_low_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo_i |=> (cnt_q[31:0] == $past(wdata_i)));
endmodule

// File: rtl/evt_glb_ctrl.sv
module evt_glb_ctrl #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr_i,
  input  logic [1:0]     cfg_wdata_i,
  input  logic           sts_wr_i,
  input  logic [NCH-1:0] sts_wdata_i,
  input  logic [NCH-1:0] fire_i,
  input  logic [NCH-1:0] cmp_ones_i,
  output logic           en_o,
  output logic           legacy_o,
  output logic [NCH-1:0] sts_o,
  output logic [NCH-1:0] arm_o,
  output logic [NCH-1:0] disarm_o
);
  logic           en_q, en_d;
  logic           leg_q, leg_d;
  logic [NCH-1:0] sts_q, sts_d;
  logic [NCH-1:0] arm_q, arm_d;
  logic [NCH-1:0] dis_q, dis_d;

  always_comb begin
    en_d  = en_q;
    leg_d = leg_q;
    arm_d = '0;
    dis_d = '0;
    if (cfg_wr_i) begin
      en_d  = cfg_wdata_i[0];
      leg_d = cfg_wdata_i[1];
      if (cfg_wdata_i[0] && !en_q) arm_d = ~cmp_ones_i;
      if (!cfg_wdata_i[0] && en_q) dis_d = '1;
    end
    sts_d = (sts_q & ~(sts_wr_i ? sts_wdata_i : '0)) | fire_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      leg_q <= 1'b0;
      sts_q <= '0;
      arm_q <= '0;
      dis_q <= '0;
    end else begin
      if (cfg_wr_i) begin
        en_q  <= en_d;
        leg_q <= leg_d;
      end
      sts_q <= sts_d;
      arm_q <= arm_d;
      dis_q <= dis_d;
    end
  end

  assign en_o     = en_q;
  assign legacy_o = leg_q;
  assign sts_o    = sts_q;
  assign arm_o    = arm_q;
  assign disarm_o = dis_q;

  a_r7_arm_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (|arm_o) |-> (en_q && !$past(en_q)));
  a_r8_disarm_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (|disarm_o) |-> (!en_q && $past(en_q)));
  a_r8_fall_hits_all: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> (&disarm_o));
  a_r10_fire_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|fire_i) |=> ((sts_q & $past(fire_i)) == $past(fire_i)));
endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_timer_pkg::*;
#(
  parameter int          NCH     = 3,
  parameter logic [31:0] TICK_FS = 32'd10_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic             acc_wr,
  input  logic [1:0]       acc_size,
  input  logic [9:0]       acc_addr,
  input  logic [31:0]      acc_wdata,
  output logic [31:0]      rd_data,
  output logic [NCH-1:0]   ch_sel,
  output logic             ch_wr,
  output logic [4:0]       ch_reg_off,
  input  logic [NCH*32-1:0] ch_rdata,
  input  logic [NCH-1:0]   ch_fire,
  input  logic [NCH-1:0]   ch_cmp_ones,
  output logic [NCH-1:0]   ch_arm,
  output logic [NCH-1:0]   ch_disarm,
  output logic [63:0]      cnt_value,
  output logic             glb_enable,
  output logic             glb_legacy
);
  localparam logic [4:0]  NCH_M1 = 5'(NCH - 1);
  localparam logic [31:0] CAP_LO = {16'h8086, 1'b1, 1'b0, 1'b1, NCH_M1, 8'h01};

  rsel_e          sel;
  logic           wr_ok;
  logic [NCH-1:0] sts;

  evt_addr_decode #(.NCH(NCH)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_en_i   (acc_en),
    .acc_size_i (acc_size),
    .acc_addr_i (acc_addr),
    .sel_o      (sel),
    .ch_sel_o   (ch_sel),
    .ch_off_o   (ch_reg_off)
  );

  assign wr_ok = acc_wr && (sel != RS_NONE);
  assign ch_wr = acc_wr && (|ch_sel);

  evt_main_counter #(.CNT_W(64)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (glb_enable),
    .wr_lo_i (wr_ok && sel == RS_CNT_LO),
    .wr_hi_i (wr_ok && sel == RS_CNT_HI),
    .wdata_i (acc_wdata),
    .cnt_o   (cnt_value)
  );

  evt_glb_ctrl #(.NCH(NCH)) u_glb (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_i    (wr_ok && sel == RS_CFG_LO),
    .cfg_wdata_i (acc_wdata[1:0]),
    .sts_wr_i    (wr_ok && sel == RS_STS),
    .sts_wdata_i (acc_wdata[NCH-1:0]),
    .fire_i      (ch_fire),
    .cmp_ones_i  (ch_cmp_ones),
    .en_o        (glb_enable),
    .legacy_o    (glb_legacy),
    .sts_o       (sts),
    .arm_o       (ch_arm),
    .disarm_o    (ch_disarm)
  );

  always_comb begin
    rd_data = '0;
    if (acc_en && !acc_wr) begin
      case (sel)
        RS_CAP_LO: rd_data = CAP_LO;
        RS_CAP_HI: rd_data = TICK_FS;
        RS_CFG_LO: rd_data = {30'd0, glb_legacy, glb_enable};
        RS_STS:    rd_data[NCH-1:0] = sts;
        RS_CNT_LO: rd_data = cnt_value[31:0];
        RS_CNT_HI: rd_data = cnt_value[63:32];
        RS_CHAN: begin
          for (int i = 0; i < NCH; i++) begin
            if (ch_sel[i]) rd_data = ch_rdata[i*32 +: 32];
          end
        end
        default:   rd_data = '0;
      endcase
    end
  end

  // R3 / R12: nothing but a decoded word read may drive read data
  a_r12_idle_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == RS_NONE) |-> (rd_data == 32'd0));
endmodule

// File: tb/sim_evt_timer_regs.sv
module sim_evt_timer_regs;
  localparam int NCH = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             acc_en = 1'b0, acc_wr = 1'b0;
  logic [1:0]       acc_size = 2'd2;
  logic [9:0]       acc_addr = '0;
  logic [31:0]      acc_wdata = '0;
  logic [31:0]      rd_data;
  logic [NCH-1:0]   ch_sel, ch_arm, ch_disarm;
  logic             ch_wr;
  logic [4:0]       ch_reg_off;
  logic [NCH*32-1:0] ch_rdata;
  logic [NCH-1:0]   ch_fire = '0, ch_cmp_ones = '0;
  logic [63:0]      cnt_value;
  logic             glb_enable, glb_legacy;
  logic [31:0]      chdat [NCH];

  assign ch_rdata = {chdat[2], chdat[1], chdat[0]};

  always #5 clk = ~clk;

  evt_timer_regs #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_size(acc_size),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data), .ch_sel(ch_sel),
    .ch_wr(ch_wr), .ch_reg_off(ch_reg_off), .ch_rdata(ch_rdata), .ch_fire(ch_fire),
    .ch_cmp_ones(ch_cmp_ones), .ch_arm(ch_arm), .ch_disarm(ch_disarm),
    .cnt_value(cnt_value), .glb_enable(glb_enable), .glb_legacy(glb_legacy)
  );

  int   n_chk = 0, n_err = 0;
  bit   done = 1'b0;

  // behavioural reference model
  logic [63:0]    m_cnt;
  logic [1:0]     m_cfg;
  logic [NCH-1:0] m_sts, m_arm, m_dis;

  always @(posedge clk) begin
    logic w, old_en;
    if (!rst_n) begin
      m_cnt = '0; m_cfg = '0; m_sts = '0; m_arm = '0; m_dis = '0;
    end else begin
      w = acc_en && acc_wr && acc_size == 2'd2 && acc_addr[1:0] == 2'b00;
      old_en = m_cfg[0];
      m_arm = '0; m_dis = '0;
      if (w && acc_addr == 10'h010) begin
        if (acc_wdata[0] && !old_en) m_arm = ~ch_cmp_ones;
        if (!acc_wdata[0] && old_en) m_dis = '1;
        m_cfg = acc_wdata[1:0];
      end
      if (w && acc_addr == 10'h0F0)      m_cnt[31:0]  = acc_wdata;
      else if (w && acc_addr == 10'h0F4) m_cnt[63:32] = acc_wdata;
      else if (old_en)                   m_cnt = m_cnt + 64'd1;
      m_sts = (m_sts & ~((w && acc_addr == 10'h020) ? acc_wdata[NCH-1:0] : '0)) | ch_fire;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 counter", cnt_value, m_cnt);
      chk("R4 enable", {63'd0, glb_enable}, {63'd0, m_cfg[0]});
      chk("R11 legacy", {63'd0, glb_legacy}, {63'd0, m_cfg[1]});
      chk("R7 arm", {61'd0, ch_arm}, {61'd0, m_arm});
      chk("R8 disarm", {61'd0, ch_disarm}, {61'd0, m_dis});
    end
  end

  function automatic logic [31:0] exp_rd(logic [9:0] a, logic [1:0] sz);
    if (sz != 2'd2 || a[1:0] != 2'b00) return 32'd0;
    if (a >= 10'h100) begin
      int k;
      k = (int'(a) - 256) / 32;
      return (k < NCH) ? chdat[k] : 32'd0;
    end
    case (a)
      10'h000: return 32'h8086A201;
      10'h004: return 32'd10_000_000;
      10'h010: return {30'd0, m_cfg};
      10'h020: return {29'd0, m_sts};
      10'h0F0: return m_cnt[31:0];
      10'h0F4: return m_cnt[63:32];
      default: return 32'd0;
    endcase
  endfunction

  // caller is at a falling edge; access occupies one cycle
  task automatic wr(logic [9:0] a, logic [31:0] d, logic [1:0] sz = 2'd2);
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d; acc_size = sz;
    @(posedge clk); @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0; acc_size = 2'd2;
  endtask

  task automatic rd(string req, logic [9:0] a, logic [1:0] sz = 2'd2);
    logic [NCH-1:0] exp_sel;
    int k;
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a; acc_size = sz;
    #1;
    chk(req, {32'd0, rd_data}, {32'd0, exp_rd(a, sz)});
    if (a >= 10'h100) begin
      k = (int'(a) - 256) / 32;
      exp_sel = (k < NCH && sz == 2'd2 && a[1:0] == 2'b00) ? NCH'(1 << k) : '0;
      chk("R9 select", {61'd0, ch_sel}, {61'd0, exp_sel});
      if (exp_sel != '0) chk("R9 offset", {59'd0, ch_reg_off}, {59'd0, a[4:0]});
    end
    @(posedge clk); @(negedge clk);
    acc_en = 1'b0; acc_size = 2'd2;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    chdat[0] = 32'hA0A0_0001; chdat[1] = 32'hB1B1_0002; chdat[2] = 32'hC2C2_0003;
    repeat (3) @(negedge clk);
    // R1 reset state while held
    chk("R1 counter", cnt_value, 64'd0);
    chk("R1 flags", {60'd0, glb_enable, glb_legacy, |ch_arm, |ch_disarm}, 64'd0);
    rst_n = 1'b1;
    idle(2);
    chk("R1 after release", cnt_value, 64'd0);
    rd("R1 status", 10'h020);
    rd("R1 config", 10'h010);

    rd("R2 cap low", 10'h000);
    chk("R2 cap value", {32'd0, exp_rd(10'h000, 2'd2)}, 64'h8086A201);
    rd("R2 tick period", 10'h004);

    // R3 narrow accesses
    rd("R3 byte read", 10'h000, 2'd0);
    rd("R3 half read", 10'h004, 2'd1);
    wr(10'h010, 32'h3, 2'd0);
    chk("R3 byte write ignored", {63'd0, glb_enable}, 64'd0);
    wr(10'h0F0, 32'h1234, 2'd1);
    chk("R3 half write ignored", cnt_value, 64'd0);
    rd("R3 misaligned", 10'h012);

    // R4 / R7 / R11 enable rise with channel 1 comparator all ones
    ch_cmp_ones = 3'b010;
    wr(10'h010, 32'hFFFF_FFFF);
    chk("R7 arm pulse", {61'd0, ch_arm}, 64'h5);
    chk("R11 legacy set", {63'd0, glb_legacy}, 64'd1);
    rd("R4 config mask", 10'h010);
    chk("R7 arm single cycle", {61'd0, ch_arm}, 64'd0);
    wr(10'h014, 32'hFFFF_FFFF);
    rd("R4 upper word", 10'h014);
    wr(10'h010, 32'h1);             // enable already on: no new arm
    chk("R7 no re-arm", {61'd0, ch_arm}, 64'd0);
    chk("R11 legacy clear", {63'd0, glb_legacy}, 64'd0);

    idle(10);
    rd("R5 running low", 10'h0F0);

    // R6 half writes while enabled
    wr(10'h0F0, 32'hFFFF_FFFE);
    chk("R6 low write", {32'd0, cnt_value[31:0]}, 64'hFFFF_FFFE);
    idle(3);
    rd("R5 carry high", 10'h0F4);
    wr(10'h0F4, 32'h0000_00AB);
    chk("R6 high write", {32'd0, cnt_value[63:32]}, 64'hAB);

    // R8 enable fall
    wr(10'h010, 32'h0);
    chk("R8 disarm all", {61'd0, ch_disarm}, 64'h7);
    idle(5);
    rd("R5 frozen", 10'h0F0);
    wr(10'h0F0, 32'h0000_0010);
    chk("R6 write while off", {32'd0, cnt_value[31:0]}, 64'h10);

    // R9 channel windows
    rd("R9 chan0", 10'h100);
    rd("R9 chan1 off8", 10'h128);
    rd("R9 chan2 off10", 10'h150);
    rd("R9 chan3 absent", 10'h160);
    rd("R9 chan far", 10'h3FC);
    rd("R9 chan byte", 10'h120, 2'd0);

    // R10 status
    ch_fire = 3'b011; @(negedge clk); ch_fire = '0;
    rd("R10 status set", 10'h020);
    wr(10'h020, 32'h1);
    rd("R10 w1c", 10'h020);
    ch_fire = 3'b010;
    wr(10'h020, 32'h2);             // fire beats clear
    ch_fire = '0;
    rd("R10 fire wins", 10'h020);
    chk("R10 bit1 held", {32'd0, exp_rd(10'h020, 2'd2)}, 64'h2);

    // R12 unmapped
    rd("R12 unmapped", 10'h030);
    rd("R12 unmapped2", 10'h0F8);

    idle(2);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule